// File: doc/BRIEF.md
# Windowed Memory Address Translator

This block turns two kinds of processor address into a physical memory target and an offset within it. A 16-bit data address and an 18-bit instruction byte address are translated at the same time, each to one of three targets: internal data RAM, instruction RAM, or a numbered unified-memory segment of 128 KB. Each translation also reports a bus error when the access is illegal. The memories themselves live outside the block.

Three 16-bit mapping registers steer the translation. A data map controls a 16 KB window at data addresses 0x8000 to 0xBFFF. Two instruction maps each control one half of the instruction space. In each map, bit 12 chooses between instruction RAM and paged unified memory. The maps are loaded through a one-cycle register-write port. A 128-bit presence mask tells the block which unified segments exist, and an access to any other segment is flagged. Translation is combinational from the address inputs and the current map values, so a map write changes the result from the following cycle on.

Top module: `memwin_xlat`

## Requirements
- R1: When synchronous reset is released, both instruction maps hold 0x1000 and the data map holds 0. As a result, all instruction fetches go to instruction RAM, and the data window goes to unified segment 0.
- R2: A data address below 0x8000 gives target code 2'b00 (data RAM), an offset equal to the address, segment 0 and no error.
- R3: A data address of 0xC000 or above gives target 2'b00 with the address as its offset and segment 0. The error flag is low only for 0xFF00 through 0xFF0F.
- R4: A data address in 0x8000..0xBFFF with data-map bit 12 set gives target 2'b01 (instruction RAM). The offset is map[3:0]·16384 + (address mod 16384), the segment is 0 and there is no error.
- R5: A data address in the window with data-map bit 12 clear gives target 2'b10 (unified). The segment is map[9:3] and the offset is map[2:0]·16384 + (address mod 16384).
- R6: An instruction address with bit 17 set is translated through instruction map 1. With bit 17 clear it goes through instruction map 0.
- R7: When the selected instruction map has bit 12 set, the result is target 2'b01 with the full 18-bit byte address as offset, segment 0 and no error.
- R8: When the selected instruction map has bit 12 clear, the result is target 2'b10 with segment map[7:0] and offset equal to (address mod 131072).
- R9: A unified result raises the error flag exactly when its segment is 128 or above, or when its bit in the presence mask is 0.
- R10: A write with select 0 loads the data map, select 1 loads instruction map 0 and select 2 loads instruction map 1. Select 3 changes nothing. A write becomes visible in the cycle after it is presented, and writes presented during reset are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_sel | input | 2 | Map register select (0 data, 1 instr map 0, 2 instr map 1) |
| map_wr_data | input | 16 | Value to load |
| seg_present | input | 128 | One bit per unified segment that exists |
| d_addr | input | 16 | Data address |
| d_tgt | output | 2 | Data target code |
| d_seg | output | 7 | Data unified segment |
| d_off | output | 18 | Data physical offset |
| d_err | output | 1 | Data bus error |
| i_addr | input | 18 | Instruction byte address |
| i_tgt | output | 2 | Instruction target code |
| i_seg | output | 8 | Instruction unified segment |
| i_off | output | 18 | Instruction physical offset |
| i_err | output | 1 | Instruction bus error |

## Verification
Every translated output is due in the same cycle as its address and presence inputs, with no register in between. The bench therefore drives inputs on the falling edge and compares a quarter period later, within the same low phase. A map write is due one rising edge after it is presented. The bench model commits writes only at the rising edge, so the comparison made in the write cycle still expects the old mapping and the next comparison expects the new one. Comparisons start in the first cycle after reset is released, which is where the reset values of the maps become observable.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int DADDR_W  = 16;
    localparam int IADDR_W  = 18;
    localparam int MAP_W    = 16;
    localparam int NMAPS    = 3;
    localparam int SEL_W    = 2;
    localparam int NSEG     = 128;
    localparam int DSEG_W   = $clog2(NSEG);
    localparam int ISEG_W   = 8;
    localparam int OFF_W    = 18;
    localparam int PAGE_W   = 14;
    localparam int SEGOFF_W = 17;
    localparam int MAP_FLAG = 12;

    localparam logic [DADDR_W-1:0] WIN_LO   = 16'h8000;
    localparam logic [DADDR_W-1:0] IO_LO    = 16'hC000;
    localparam logic [11:0]        IO_LEGAL = 12'hFF0;
    localparam logic [MAP_W-1:0]   IMAP_RST = 16'h1000;
    localparam logic [MAP_W-1:0]   DMAP_RST = 16'h0000;

    localparam logic [SEL_W-1:0] SEL_DMAP  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_IMAP0 = 2'd1;
    localparam logic [SEL_W-1:0] SEL_IMAP1 = 2'd2;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'b00,
        TGT_IRAM = 2'b01,
        TGT_UNI  = 2'b10
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ISEG_W-1:0] seg;
        logic [OFF_W-1:0]  off;
        logic              err;
    } xlat_t;

    function automatic logic seg_missing(input logic [NSEG-1:0] mask,
                                         input logic [ISEG_W-1:0] seg);
        logic miss;
        miss = 1'b1;
        for (int k = 0; k < NSEG; k++) begin
            if (int'(seg) == k) miss = !mask[k];
        end
        return miss;
    endfunction

    function automatic logic [MAP_W-1:0] map_reset_val(input int idx);
        return (idx == int'(SEL_DMAP)) ? DMAP_RST : IMAP_RST;
    endfunction
endpackage

// File: rtl/memwin_map_regs.sv
module memwin_map_regs
    import memwin_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [MAP_W-1:0]            wr_data,
    output logic [NMAPS-1:0][MAP_W-1:0] map_q
);
    for (genvar g = 0; g < NMAPS; g++) begin : g_map
        localparam logic [MAP_W-1:0] RVAL = map_reset_val(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[g] <= RVAL;
            end else if (wr_en && (int'(wr_sel) == g)) begin
                map_q[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/memwin_data_xlat.sv
module memwin_data_xlat
    import memwin_pkg::*;
(
    input  logic [DADDR_W-1:0] addr,
    input  logic [MAP_W-1:0]   dmap,
    input  logic [NSEG-1:0]    present,
    output xlat_t              res
);
    always_comb begin
        res     = '0;
        res.tgt = TGT_DRAM;
        res.off = OFF_W'(addr);
        if (addr >= IO_LO) begin
            res.err = (addr[DADDR_W-1:4] != IO_LEGAL);
        end else if (addr >= WIN_LO) begin
            if (dmap[MAP_FLAG]) begin
                res.tgt = TGT_IRAM;
                res.off = {dmap[3:0], addr[PAGE_W-1:0]};
            end else begin
                res.tgt = TGT_UNI;
                res.seg = ISEG_W'(dmap[9:3]);
                res.off = OFF_W'({dmap[2:0], addr[PAGE_W-1:0]});
                res.err = seg_missing(present, ISEG_W'(dmap[9:3]));
            end
        end
    end
endmodule

// File: rtl/memwin_inst_xlat.sv
module memwin_inst_xlat
    import memwin_pkg::*;
(
    input  logic [IADDR_W-1:0] addr,
    input  logic [MAP_W-1:0]   imap0,
    input  logic [MAP_W-1:0]   imap1,
    input  logic [NSEG-1:0]    present,
    output xlat_t              res
);
    logic [MAP_W-1:0] sel_map;

    always_comb begin
        sel_map = addr[IADDR_W-1] ? imap1 : imap0;
        res     = '0;
        if (sel_map[MAP_FLAG]) begin
            res.tgt = TGT_IRAM;
            res.off = OFF_W'(addr);
        end else begin
            res.tgt = TGT_UNI;
            res.seg = sel_map[ISEG_W-1:0];
            res.off = OFF_W'(addr[SEGOFF_W-1:0]);
            res.err = seg_missing(present, sel_map[ISEG_W-1:0]);
        end
    end
endmodule

// File: rtl/memwin_xlat.sv
module memwin_xlat
    import memwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                map_wr_en,
    input  logic [1:0]          map_wr_sel,
    input  logic [15:0]         map_wr_data,
    input  logic [127:0]        seg_present,
    input  logic [15:0]         d_addr,
    output logic [1:0]          d_tgt,
    output logic [6:0]          d_seg,
    output logic [17:0]         d_off,
    output logic                d_err,
    input  logic [17:0]         i_addr,
    output logic [1:0]          i_tgt,
    output logic [7:0]          i_seg,
    output logic [17:0]         i_off,
    output logic                i_err
);
    logic [NMAPS-1:0][MAP_W-1:0] maps;
    xlat_t d_res;
    xlat_t i_res;

    memwin_map_regs u_maps (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (map_wr_en),
        .wr_sel  (map_wr_sel),
        .wr_data (map_wr_data),
        .map_q   (maps)
    );

    memwin_data_xlat u_dx (
        .addr    (d_addr),
        .dmap    (maps[SEL_DMAP]),
        .present (seg_present),
        .res     (d_res)
    );

    memwin_inst_xlat u_ix (
        .addr    (i_addr),
        .imap0   (maps[SEL_IMAP0]),
        .imap1   (maps[SEL_IMAP1]),
        .present (seg_present),
        .res     (i_res)
    );

    assign d_tgt = d_res.tgt;
    assign d_seg = d_res.seg[DSEG_W-1:0];
    assign d_off = d_res.off;
    assign d_err = d_res.err;
    assign i_tgt = i_res.tgt;
    assign i_seg = i_res.seg;
    assign i_off = i_res.off;
    assign i_err = i_res.err;
endmodule

// File: rtl/memwin_xlat_chk.sv
module memwin_xlat_chk (
    input logic         clk,
    input logic         rst,
    input logic         map_wr_en,
    input logic [1:0]   map_wr_sel,
    input logic [15:0]  map_wr_data,
    input logic [127:0] seg_present,
    input logic [15:0]  d_addr,
    input logic [1:0]   d_tgt,
    input logic [6:0]   d_seg,
    input logic [17:0]  d_off,
    input logic         d_err,
    input logic [17:0]  i_addr,
    input logic [1:0]   i_tgt,
    input logic [7:0]   i_seg,
    input logic [17:0]  i_off,
    input logic         i_err
);
    // R1
    reset_fetch_chk: assert property (@(posedge clk)
        $fell(rst) |-> (i_tgt == 2'b01 && !i_err));

    // R2
    low_dram_chk: assert property (@(posedge clk) disable iff (rst)
        (d_addr < 16'h8000) |-> (d_tgt == 2'b00 && d_off == {2'b00, d_addr} && !d_err));

    // R3
    io_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (d_addr >= 16'hFF00 && d_addr <= 16'hFF0F) |-> (d_tgt == 2'b00 && !d_err));

    // R3
    io_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (d_addr >= 16'hC000 && (d_addr < 16'hFF00 || d_addr > 16'hFF0F)) |-> d_err);

    // R7
    iram_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (i_tgt == 2'b01) |-> (i_off == i_addr && i_seg == 8'd0 && !i_err));

    // R9
    inst_missing_chk: assert property (@(posedge clk) disable iff (rst)
        (i_tgt == 2'b10 && i_seg[7] == 1'b0 && seg_present[i_seg[6:0]]) |-> !i_err);

    // R9
    inst_high_seg_chk: assert property (@(posedge clk) disable iff (rst)
        (i_tgt == 2'b10 && i_seg[7] == 1'b1) |-> i_err);

    // R10
    imap0_write_chk: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && map_wr_sel == 2'd1 && map_wr_data[12]) |=>
        (i_addr[17] || i_tgt == 2'b01));
endmodule

bind memwin_xlat memwin_xlat_chk chk_i (.*);

// File: tb/memwin_xlat_tb.sv
module memwin_xlat_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         map_wr_en = 1'b0;
    logic [1:0]   map_wr_sel = 2'd0;
    logic [15:0]  map_wr_data = 16'd0;
    logic [127:0] seg_present = '0;
    logic [15:0]  d_addr = 16'd0;
    logic [17:0]  i_addr = 18'd0;
    logic [1:0]   d_tgt;
    logic [6:0]   d_seg;
    logic [17:0]  d_off;
    logic         d_err;
    logic [1:0]   i_tgt;
    logic [7:0]   i_seg;
    logic [17:0]  i_off;
    logic         i_err;

    int n_cmp = 0;
    int n_bad = 0;
    int m_dmap = 0;
    int m_im0  = 0;
    int m_im1  = 0;
    bit done = 1'b0;

    memwin_xlat dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model: map state changes only at a rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_dmap = 0;
            m_im0  = 4096;
            m_im1  = 4096;
        end else if (map_wr_en) begin
            if (map_wr_sel == 2'd0) m_dmap = int'(map_wr_data);
            else if (map_wr_sel == 2'd1) m_im0 = int'(map_wr_data);
            else if (map_wr_sel == 2'd2) m_im1 = int'(map_wr_data);
        end
    end

    function automatic bit seg_ok(input int s);
        return (s < 128) && seg_present[s];
    endfunction

    task automatic compare(input string tag);
        int d, i, m;
        int e_dt, e_ds, e_do, e_de, e_it, e_is, e_io, e_ie;
        d = int'(d_addr);
        i = int'(i_addr);
        e_ds = 0; e_de = 0; e_dt = 0; e_do = d;
        if (d >= 49152) begin
            e_de = (d >= 65280 && d <= 65295) ? 0 : 1;
        end else if (d >= 32768) begin
            if (((m_dmap / 4096) % 2) == 1) begin
                e_dt = 1;
                e_do = (m_dmap % 16) * 16384 + d % 16384;
            end else begin
                e_dt = 2;
                e_ds = (m_dmap / 8) % 128;
                e_do = (m_dmap % 8) * 16384 + d % 16384;
                e_de = seg_ok(e_ds) ? 0 : 1;
            end
        end
        m = (i >= 131072) ? m_im1 : m_im0;
        e_is = 0; e_ie = 0;
        if (((m / 4096) % 2) == 1) begin
            e_it = 1;
            e_io = i;
        end else begin
            e_it = 2;
            e_is = m % 256;
            e_io = i % 131072;
            e_ie = seg_ok(e_is) ? 0 : 1;
        end
        n_cmp++;
        if (int'(d_tgt) != e_dt || int'(d_seg) != e_ds || int'(d_off) != e_do ||
            int'(d_err) != e_de || int'(i_tgt) != e_it || int'(i_seg) != e_is ||
            int'(i_off) != e_io || int'(i_err) != e_ie) begin
            n_bad++;
            $display("FAIL %s d_addr=%h i_addr=%h actual d=%0d/%0d/%h/%0d i=%0d/%0d/%h/%0d expected d=%0d/%0d/%h/%0d i=%0d/%0d/%h/%0d",
                     tag, d_addr, i_addr, d_tgt, d_seg, d_off, d_err, i_tgt, i_seg, i_off, i_err,
                     e_dt, e_ds, e_do, e_de, e_it, e_is, e_io, e_ie);
        end
    endtask

    task automatic cyc(input string tag, input logic [15:0] da, input logic [17:0] ia,
                       input logic we, input logic [1:0] ws, input logic [15:0] wd);
        @(negedge clk);
        d_addr = da;
        i_addr = ia;
        map_wr_en = we;
        map_wr_sel = ws;
        map_wr_data = wd;
        #(CLK_PERIOD/4);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        seg_present = ~(128'b1 << 127);
        // R10: write offered during reset must be discarded
        repeat (3) begin
            @(negedge clk);
            map_wr_en = 1'b1; map_wr_sel = 2'd0; map_wr_data = 16'h1FFF;
        end
        @(negedge clk);
        rst = 1'b0;
        map_wr_en = 1'b0;
        #(CLK_PERIOD/4);
        compare("R1");
        cyc("R1", 16'h9234, 18'h00100, 0, 2'd0, 16'h0);
        cyc("R1", 16'hB000, 18'h20100, 0, 2'd0, 16'h0);
        cyc("R2", 16'h0000, 18'h3FFFF, 0, 2'd0, 16'h0);
        cyc("R2", 16'h7FFF, 18'h1FFFF, 0, 2'd0, 16'h0);
        cyc("R3", 16'hC000, 18'h0, 0, 2'd0, 16'h0);
        cyc("R3", 16'hFF00, 18'h0, 0, 2'd0, 16'h0);
        cyc("R3", 16'hFF0F, 18'h0, 0, 2'd0, 16'h0);
        cyc("R3", 16'hFF10, 18'h0, 0, 2'd0, 16'h0);
        cyc("R3", 16'hFEFF, 18'h0, 0, 2'd0, 16'h0);
        cyc("R3", 16'hFFFF, 18'h0, 0, 2'd0, 16'h0);
        cyc("R10", 16'h8000, 18'h0, 1, 2'd0, 16'h1005);
        cyc("R4", 16'h8000, 18'h0, 0, 2'd0, 16'h0);
        cyc("R4", 16'hBFFF, 18'h0, 1, 2'd0, 16'h100F);
        cyc("R4", 16'hBFFF, 18'h0, 1, 2'd0, 16'h03FD);
        cyc("R9", 16'h8123, 18'h0, 0, 2'd0, 16'h0);
        seg_present = '1;
        cyc("R9", 16'h8123, 18'h0, 1, 2'd0, 16'h0012);
        cyc("R5", 16'hA456, 18'h0, 1, 2'd1, 16'h0005);
        cyc("R8", 16'h0, 18'h1FFFF, 1, 2'd2, 16'h00FF);
        cyc("R6", 16'h0, 18'h3ABCD, 0, 2'd0, 16'h0);
        cyc("R9", 16'h0, 18'h2ABCD, 1, 2'd2, 16'h1000);
        cyc("R7", 16'h0, 18'h3ABCD, 0, 2'd0, 16'h0);
        cyc("R6", 16'h0, 18'h00010, 1, 2'd3, 16'hFFFF);
        cyc("R10", 16'h0, 18'h00010, 0, 2'd0, 16'h0);
        seg_present = ~(128'b1 << 5);
        cyc("R9", 16'h0, 18'h00010, 0, 2'd0, 16'h0);
        for (int n = 0; n < 400; n++) begin
            seg_present = {$urandom, $urandom, $urandom, $urandom};
            cyc("R10", 16'($urandom), 18'($urandom), 1'($urandom), 2'($urandom), 16'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule